// File: doc/BRIEF.md
# Sleep Wake-Up Source Controller

This block decides when a sleeping processor must be brought back. Firmware can arm an 8-bit seconds timer. It can also enable any of three general-purpose pins as wake inputs. A push-button and the idle-high serial receive line are always wake sources. While the low-power request is held (full sleep or display-only), the first wake event produces a one-cycle wake request. The same event records its source in a flag vector that firmware reads after resuming.

Each pin and the button pass through a two-stage synchronizer and a counter filter. The filter accepts a new level only after that level has been seen on a programmable number of consecutive sample ticks. The receive line is only synchronized. The wake timer is loaded when it is armed. It counts one-pulse-per-second ticks only while the controller sleeps, and it expires on the tick after its count reaches zero.

Three mode states govern the block:

- **AWAKE**: the processor runs.
  - AWAKE → ASLEEP when either low-power request rises. This entry clears every flag.
- **ASLEEP**: wake events are accepted.
  - ASLEEP → WOKEN on the first wake event.
  - ASLEEP → AWAKE if the request is withdrawn.
- **WOKEN**: ignores events.
  - WOKEN → AWAKE once the request falls.

The timer has two states:

- **TMR_IDLE** → **TMR_RUN** on an arm write of 1. This reloads the count.
- **TMR_RUN** → **TMR_IDLE** on expiry, on any other wake event, or on an arm write of 0.

Top module: `wake_ctrl`

## Requirements
- R1: After reset, `wake_flags_o`, `armed_o`, `tmr_val_o` and `wake_req_o` are all zero.
- R2: A timer value write stores its data, which is visible on `tmr_val_o`. An arm write of 1 loads the timer and sets `armed_o`. An arm write of 0 clears `armed_o`.
- R3: The armed timer ignores second ticks unless the controller is in ASLEEP. Ticks given while awake leave the full delay intact.
- R4: With a loaded value V, the timer wake fires on the (V+1)-th second tick in ASLEEP. It sets flag bit 3, pulses `wake_req_o` in the cycle after that tick, and clears `armed_o`.
- R5: In ASLEEP, a rising edge of the filtered level of pin i, with `pin_wake_en_i[i]`=1, sets flag bit i (i = 0..2) and requests wake.
- R6: A pin whose enable bit is 0 causes no wake. Its flag bit is forced to 0 one cycle after the enable is low, even if it was set.
- R7: The filter changes its level only after the raw level differs for max(`deb_len_i`,1) consecutive sample ticks. Shorter pulses produce no flag and no wake.
- R8: A filtered rising edge of the button sets flag bit 4. A falling edge of the receive line sets flag bit 5. Each of these wakes the block from ASLEEP.
- R9: `wake_req_o` is a single-cycle pulse. A wake from a source other than the timer disarms the timer. No further events are accepted in WOKEN until the request falls and is raised again.
- R10: Writing a 1 in `flag_clr_mask_i` clears that flag bit. Flags persist after the request falls. The next entry into ASLEEP clears them all.
- R11: Two sources firing in the same cycle set both their flags and give a single wake pulse.
- R12: Events that occur while the controller is not in ASLEEP set no flag and request no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| sample_tick_i | input | 1 | Filter sample strobe |
| sleep_req_i | input | 1 | Full sleep request |
| lcd_only_req_i | input | 1 | Display-only low-power request |
| tmr_val_we_i | input | 1 | Timer value write strobe |
| tmr_val_wdata_i | input | 8 | Timer value write data |
| arm_we_i | input | 1 | Arm bit write strobe |
| arm_wdata_i | input | 1 | Arm bit write data |
| pin_i | input | 3 | General-purpose wake pins |
| pin_wake_en_i | input | 3 | Per-pin wake enable |
| button_i | input | 1 | Push-button input |
| rx_i | input | 1 | Serial receive line, idle high |
| deb_len_i | input | 4 | Filter length in sample ticks |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_mask_i | input | 6 | Write-1-to-clear flag mask |
| wake_req_o | output | 1 | Wake request pulse |
| wake_flags_o | output | 6 | Wake flags: bits 0-2 pins, 3 timer, 4 button, 5 receive |
| tmr_val_o | output | 8 | Stored timer value |
| armed_o | output | 1 | Timer armed |

## Verification
The bench sweeps timer values 0 to 7 and 255, and checks one tick before expiry and at expiry. An off-by-one counter would wake a second early or a second late. It sweeps filter lengths 0 to 5 against pulse widths 1 to 6. A filter that counts wrongly would let a short glitch wake the part, or would reject a valid press. It also covers these cases:
- Masked pins, which a faulty mask would let wake the part or leave flagged.
- Ticks given while awake, which a free-running counter would consume.
- Events in WOKEN, which a design lacking that state would turn into repeated pulses.
- Two pins rising together, where a priority encoder would lose one flag.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        MODE_AWAKE  = 2'd0,
        MODE_ASLEEP = 2'd1,
        MODE_WOKEN  = 2'd2
    } mode_state_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/wake_sync_deb.sv
module wake_sync_deb #(
    parameter int DEB_W   = 4,
    parameter bit RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             raw_i,
    input  logic [DEB_W-1:0] len_i,
    output logic             level_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [1:0]       sync_q;
    logic [DEB_W-1:0] run_q;
    logic             level_q;
    logic             prev_q;
    logic [DEB_W:0]   need;
    logic [DEB_W:0]   run_next;

    assign need     = (len_i == '0) ? (DEB_W+1)'(1) : {1'b0, len_i};
    assign run_next = {1'b0, run_q} + (DEB_W+1)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {RST_VAL, RST_VAL};
        end else begin
            sync_q <= {sync_q[0], raw_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= RST_VAL;
            prev_q  <= RST_VAL;
        end else begin
            prev_q <= level_q;
            if (sample_i) begin
                if (sync_q[1] != level_q) begin
                    if (run_next >= need) begin
                        level_q <= sync_q[1];
                        run_q   <= '0;
                    end else begin
                        run_q <= run_next[DEB_W-1:0];
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    assign level_o = level_q;
    assign rise_o  = level_q & ~prev_q;
    assign fall_o  = ~level_q & prev_q;

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(level_q));

endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_we_i,
    input  logic             arm_wdata_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             abort_i,
    output logic             armed_o,
    output logic             expire_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                state_d = TMR_IDLE;
            end
            TMR_RUN: begin
                if (run_i && tick_i) begin
                    if (cnt_q == '0) begin
                        expire_o = 1'b1;
                        state_d  = TMR_IDLE;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                if (abort_i) begin
                    state_d = TMR_IDLE;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
        if (arm_we_i) begin
            if (arm_wdata_i) begin
                state_d = TMR_RUN;
                cnt_d   = load_val_i;
            end else begin
                state_d = TMR_IDLE;
            end
        end
    end

    assign armed_o = (state_q == TMR_RUN);

    // R3
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_i && tick_i) && !arm_we_i) |=> $stable(cnt_q));

    // R4
    expire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !arm_we_i) |=> !armed_o);

endmodule

// File: rtl/wake_mode_fsm.sv
module wake_mode_fsm
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req_i,
    input  logic event_any_i,
    output logic asleep_o,
    output logic enter_o,
    output logic wake_req_o
);
    mode_state_e state_q, state_d;
    logic        wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        enter_o = 1'b0;
        unique case (state_q)
            MODE_AWAKE: begin
                if (lp_req_i) begin
                    state_d = MODE_ASLEEP;
                    enter_o = 1'b1;
                end
            end
            MODE_ASLEEP: begin
                if (event_any_i) begin
                    state_d = MODE_WOKEN;
                end else if (!lp_req_i) begin
                    state_d = MODE_AWAKE;
                end
            end
            MODE_WOKEN: begin
                if (!lp_req_i) begin
                    state_d = MODE_AWAKE;
                end
            end
            default: state_d = MODE_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= (state_q == MODE_ASLEEP) && event_any_i;
        end
    end

    assign asleep_o   = (state_q == MODE_ASLEEP);
    assign wake_req_o = wake_q;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);

    // R9
    woken_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (state_q == MODE_WOKEN));

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl #(
    parameter int NUM_PINS = 3,
    parameter int TMR_W    = 8,
    parameter int DEB_W    = 4,
    localparam int FLAG_W  = NUM_PINS + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick_i,
    input  logic                sample_tick_i,
    input  logic                sleep_req_i,
    input  logic                lcd_only_req_i,
    input  logic                tmr_val_we_i,
    input  logic [TMR_W-1:0]    tmr_val_wdata_i,
    input  logic                arm_we_i,
    input  logic                arm_wdata_i,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] pin_wake_en_i,
    input  logic                button_i,
    input  logic                rx_i,
    input  logic [DEB_W-1:0]    deb_len_i,
    input  logic                flag_clr_we_i,
    input  logic [FLAG_W-1:0]   flag_clr_mask_i,
    output logic                wake_req_o,
    output logic [FLAG_W-1:0]   wake_flags_o,
    output logic [TMR_W-1:0]    tmr_val_o,
    output logic                armed_o
);
    localparam int TMR_BIT = NUM_PINS;
    localparam int BTN_BIT = NUM_PINS + 1;
    localparam int RX_BIT  = NUM_PINS + 2;

    logic [NUM_PINS-1:0] pin_rise;
    logic [NUM_PINS-1:0] pin_level;
    logic [NUM_PINS-1:0] pin_fall;
    logic                btn_level, btn_rise, btn_fall;
    logic                rx_level, rx_rise, rx_fall;
    logic                tmr_expire;
    logic                asleep;
    logic                mode_enter;
    logic                lp_req;
    logic                abort_tmr;
    logic [FLAG_W-1:0]   ev_raw, ev;
    logic [FLAG_W-1:0]   flags_q, flags_d;
    logic [TMR_W-1:0]    tmr_val_q;

    assign lp_req = sleep_req_i | lcd_only_req_i;

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        wake_sync_deb #(.DEB_W(DEB_W), .RST_VAL(1'b0)) u_pin_deb (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (sample_tick_i),
            .raw_i    (pin_i[gi]),
            .len_i    (deb_len_i),
            .level_o  (pin_level[gi]),
            .rise_o   (pin_rise[gi]),
            .fall_o   (pin_fall[gi])
        );

        // R6
        pin_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_wake_en_i[gi] |=> !flags_q[gi]);
    end

    wake_sync_deb #(.DEB_W(DEB_W), .RST_VAL(1'b0)) u_btn_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_tick_i),
        .raw_i    (button_i),
        .len_i    (deb_len_i),
        .level_o  (btn_level),
        .rise_o   (btn_rise),
        .fall_o   (btn_fall)
    );

    wake_sync_deb #(.DEB_W(DEB_W), .RST_VAL(1'b1)) u_rx_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (1'b1),
        .raw_i    (rx_i),
        .len_i    (DEB_W'(1)),
        .level_o  (rx_level),
        .rise_o   (rx_rise),
        .fall_o   (rx_fall)
    );

    always_comb begin
        ev_raw                 = '0;
        ev_raw[NUM_PINS-1:0]   = pin_rise & pin_wake_en_i;
        ev_raw[TMR_BIT]        = tmr_expire;
        ev_raw[BTN_BIT]        = btn_rise;
        ev_raw[RX_BIT]         = rx_fall;
        ev                     = asleep ? ev_raw : '0;
        abort_tmr              = |(ev & ~(FLAG_W'(1) << TMR_BIT));
    end

    wake_timer #(.CNT_W(TMR_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_we_i    (arm_we_i),
        .arm_wdata_i (arm_wdata_i),
        .load_val_i  (tmr_val_q),
        .run_i       (asleep),
        .tick_i      (sec_tick_i),
        .abort_i     (abort_tmr),
        .armed_o     (armed_o),
        .expire_o    (tmr_expire)
    );

    wake_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_req_i    (lp_req),
        .event_any_i (|ev),
        .asleep_o    (asleep),
        .enter_o     (mode_enter),
        .wake_req_o  (wake_req_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_val_q <= '0;
        end else if (tmr_val_we_i) begin
            tmr_val_q <= tmr_val_wdata_i;
        end
    end

    always_comb begin
        flags_d = flags_q;
        if (flag_clr_we_i) begin
            flags_d = flags_d & ~flag_clr_mask_i;
        end
        if (mode_enter) begin
            flags_d = '0;
        end
        flags_d                 = flags_d | ev;
        flags_d[NUM_PINS-1:0]   = flags_d[NUM_PINS-1:0] & pin_wake_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign wake_flags_o = flags_q;
    assign tmr_val_o    = tmr_val_q;

    // R12
    new_flag_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_q & ~$past(flags_q))) |-> wake_req_o);

    // R4
    tmr_flag_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[TMR_BIT]) |-> (wake_req_o && !armed_o));

endmodule

// File: tb/test_wake_ctrl.sv
module test_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       sample_tick = 1'b1;
    logic       sleep_req = 1'b0;
    logic       lcd_req = 1'b0;
    logic       val_we = 1'b0;
    logic [7:0] val_wd = 8'd0;
    logic       arm_we = 1'b0;
    logic       arm_wd = 1'b0;
    logic [2:0] pins = 3'b000;
    logic [2:0] pin_en = 3'b111;
    logic       button = 1'b0;
    logic       rx = 1'b1;
    logic [3:0] deb_len = 4'd2;
    logic       clr_we = 1'b0;
    logic [5:0] clr_mask = 6'd0;
    logic       wake_req;
    logic [5:0] flags;
    logic [7:0] tmr_val;
    logic       armed;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wake_ctrl i_wake_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .sec_tick_i      (sec_tick),
        .sample_tick_i   (sample_tick),
        .sleep_req_i     (sleep_req),
        .lcd_only_req_i  (lcd_req),
        .tmr_val_we_i    (val_we),
        .tmr_val_wdata_i (val_wd),
        .arm_we_i        (arm_we),
        .arm_wdata_i     (arm_wd),
        .pin_i           (pins),
        .pin_wake_en_i   (pin_en),
        .button_i        (button),
        .rx_i            (rx),
        .deb_len_i       (deb_len),
        .flag_clr_we_i   (clr_we),
        .flag_clr_mask_i (clr_mask),
        .wake_req_o      (wake_req),
        .wake_flags_o    (flags),
        .tmr_val_o       (tmr_val),
        .armed_o         (armed)
    );

    always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sec_pulse();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic write_val(input logic [7:0] v);
        val_we = 1'b1; val_wd = v;
        @(negedge clk);
        val_we = 1'b0;
    endtask

    task automatic write_arm(input logic a);
        arm_we = 1'b1; arm_wd = a;
        @(negedge clk);
        arm_we = 1'b0;
    endtask

    task automatic clear_flags(input logic [5:0] m);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 6'd0;
    endtask

    task automatic enter_sleep(input bit use_lcd);
        if (use_lcd) lcd_req = 1'b1; else sleep_req = 1'b1;
        cyc(2);
    endtask

    task automatic leave_sleep();
        sleep_req = 1'b0; lcd_req = 1'b0;
        cyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        check("R1 flags", flags, 0);
        check("R1 armed", armed, 0);
        check("R1 tmr_val", tmr_val, 0);
        check("R1 wake_req", wake_req, 0);

        // R2 register write and arm
        write_val(8'hA5);
        check("R2 tmr_val", tmr_val, 8'hA5);
        write_arm(1'b1);
        check("R2 armed set", armed, 1);
        write_arm(1'b0);
        check("R2 armed clear", armed, 0);

        // R4 timer sweep, V+1 seconds
        for (int idx = 0; idx < 9; idx++) begin
            int v;
            v = (idx == 8) ? 255 : idx;
            write_val(8'(v));
            write_arm(1'b1);
            enter_sleep(idx % 2 == 1);
            base = wake_cnt;
            for (int t = 0; t < v; t++) sec_pulse();
            check($sformatf("R4 no flag before V+1 V=%0d", v), flags[3], 0);
            check($sformatf("R4 still armed V=%0d", v), armed, 1);
            sec_pulse();
            check($sformatf("R4 flag at V+1 V=%0d", v), flags[3], 1);
            check($sformatf("R4 wake_req V=%0d", v), wake_req, 1);
            check($sformatf("R4 disarmed V=%0d", v), armed, 0);
            cyc(1);
            check($sformatf("R9 pulse width V=%0d", v), wake_req, 0);
            check($sformatf("R9 one pulse V=%0d", v), wake_cnt - base, 1);
            leave_sleep();
        end

        // R3 ticks while awake are ignored
        write_val(8'd3);
        write_arm(1'b1);
        for (int t = 0; t < 10; t++) sec_pulse();
        check("R3 armed after awake ticks", armed, 1);
        enter_sleep(1'b0);
        for (int t = 0; t < 3; t++) sec_pulse();
        check("R3 full delay kept", flags[3], 0);
        sec_pulse();
        check("R3 expires at 4th sleep tick", flags[3], 1);
        leave_sleep();

        // R7 filter sweep on pin 0
        pin_en = 3'b111;
        for (int n = 0; n < 6; n++) begin
            for (int l = 1; l < 7; l++) begin
                int expv;
                expv = (l >= ((n == 0) ? 1 : n)) ? 1 : 0;
                deb_len = 4'(n);
                enter_sleep(1'b0);
                base = wake_cnt;
                pins[0] = 1'b1;
                cyc(l);
                pins[0] = 1'b0;
                cyc(12);
                check($sformatf("R7 R5 flag N=%0d L=%0d", n, l), flags[0], expv);
                check($sformatf("R7 wake N=%0d L=%0d", n, l), wake_cnt - base, expv);
                leave_sleep();
            end
        end

        // R11 two pins together
        deb_len = 4'd2;
        enter_sleep(1'b0);
        base = wake_cnt;
        pins[2:1] = 2'b11;
        cyc(10);
        check("R11 both flags", flags[2:1], 3);
        check("R11 single pulse", wake_cnt - base, 1);
        pins = 3'b000;
        cyc(10);
        leave_sleep();

        // R6 disabled pin ignored
        pin_en = 3'b110;
        enter_sleep(1'b0);
        base = wake_cnt;
        pins[0] = 1'b1;
        cyc(10);
        check("R6 disabled flag", flags[0], 0);
        check("R6 disabled no wake", wake_cnt - base, 0);
        pins[0] = 1'b0;
        cyc(10);
        leave_sleep();
        // R6 flag forced clear by disable
        pin_en = 3'b111;
        enter_sleep(1'b0);
        pins[0] = 1'b1;
        cyc(10);
        check("R6 flag set when enabled", flags[0], 1);
        pin_en[0] = 1'b0;
        cyc(1);
        check("R6 flag cleared by disable", flags[0], 0);
        pins[0] = 1'b0;
        pin_en = 3'b111;
        cyc(10);
        leave_sleep();

        // R8 button; R9 disarm by other source
        write_val(8'd50);
        write_arm(1'b1);
        enter_sleep(1'b0);
        base = wake_cnt;
        button = 1'b1;
        cyc(10);
        check("R8 button flag", flags[4], 1);
        check("R8 button wake", wake_cnt - base, 1);
        check("R9 timer disarmed", armed, 0);
        // R9 events in WOKEN ignored
        pins[1] = 1'b1;
        cyc(10);
        check("R9 woken pin flag", flags[1], 0);
        check("R9 woken no pulse", wake_cnt - base, 1);
        pins[1] = 1'b0;
        button = 1'b0;
        cyc(10);
        leave_sleep();

        // R8 receive line
        enter_sleep(1'b1);
        base = wake_cnt;
        rx = 1'b0;
        cyc(6);
        check("R8 rx flag", flags[5], 1);
        check("R8 rx wake", wake_cnt - base, 1);
        rx = 1'b1;
        cyc(4);
        leave_sleep();

        // R10 persistence, clear by write, clear on entry
        check("R10 flag persists awake", flags[5], 1);
        clear_flags(6'b100000);
        check("R10 write-1 clear", flags[5], 0);
        enter_sleep(1'b0);
        button = 1'b1;
        cyc(10);
        button = 1'b0;
        cyc(10);
        leave_sleep();
        check("R10 button flag kept", flags[4], 1);
        enter_sleep(1'b0);
        check("R10 entry clears", flags, 0);
        leave_sleep();

        // R12 events while awake ignored
        clear_flags(6'h3f);
        base = wake_cnt;
        button = 1'b1;
        cyc(10);
        button = 1'b0;
        rx = 1'b0;
        cyc(6);
        rx = 1'b1;
        cyc(10);
        check("R12 awake flags", flags, 0);
        check("R12 awake no wake", wake_cnt - base, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule